// File: doc/BRIEF.md
# Paged Register File Serial Slave

This block is the serial front end of a sensor-style register map. An external master reaches it over a four-wire serial link in mode 3: the clock idles high, data is captured on the rising edge and every frame is 16 bits, most significant bit first. Each frame is a single command. It either writes one byte of a 16-bit register or asks for one 16-bit register, and the value asked for comes back during the next frame. The serial pins are brought into the system clock domain through two-stage synchronizers. The system clock must run well above the serial clock, which can reach 15 MHz. The block is only ever a slave.

The register space has 13 pages. Each page holds 64 registers of 16 bits, and every byte has its own byte address, so a page spans byte addresses 0x00 to 0x7F. The serial port sees only one page at a time. A page-select register sits at register index 0 of every page. Writing a valid code to it moves the port to another page, and reading it returns the current page.

On the sensor side, a load strobe writes a whole 16-bit word into page 0. The same strobe starts a data-ready pulse of fixed length, so the master knows fresh output data has arrived.

Top module: `paged_spi_regs`

## Requirements
- R1: A frame is 16 bits captured MSB first on rising serial clock edges while cs_n is low. The frame is acted on at its 16th rising edge, without waiting for cs_n to rise.
- R2: Frame fields: bit 15 is the direction (1 = write, 0 = read), bits 14:8 are the byte address and bits 7:0 are the write byte. Even byte addresses select register bits 7:0 and odd ones select bits 15:8. A write changes only the addressed byte.
- R3: A read frame returns the register at the even-aligned address (byte address with bit 0 cleared) on miso during the next frame, MSB first, with each bit changing on a falling serial clock edge. The frame after a write frame returns 0x0000.
- R4: Byte address 0x00 is the page-select register on every page. Writing a code from 0 to 12 there selects that page. A read of address 0x00 or 0x01 returns 0x00 in the upper byte and the current page code in the lower byte.
- R5: A page-select write with a code above 12, or any write to byte address 0x01, leaves the current page unchanged.
- R6: Each page has its own storage, so the same byte address on two pages holds two independent values.
- R7: If cs_n rises before 16 rising edges, the partial frame is dropped. It changes no register and no page, and the response still pending is shifted out in full by the next complete frame.
- R8: Reset (rst_n low) selects page 0, clears every register to 0x0000, holds miso low and clears data_ready.
- R9: A sensor_load strobe writes sensor_data into the page-0 register at sensor_idx. Index 0 is ignored, and a sensor load wins over a serial write to the same byte in the same cycle. data_ready is high for exactly DRDY_CYCLES (default 4) system clock cycles, starting at the first clock edge after the strobe.
- R10: miso is driven low while cs_n is high, and serial clock edges have no effect while cs_n is high.
- R11: Several frames can follow one another inside one low period of cs_n. Each frame is acted on at its own 16th edge and returns the response of the frame before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | Serial clock from the master, idles high |
| cs_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| sensor_load | input | 1 | One-cycle strobe: load a word into page 0 |
| sensor_idx | input | 6 | Page-0 register index to load |
| sensor_data | input | 16 | Word to load |
| data_ready | output | 1 | Pulse marking newly loaded output data |

## Verification
The bench goes after the page-select register. It writes out-of-range codes, the boundary code 12 and the upper byte 0x01, and then reads the page back; a decoder that clipped or wrapped the code would move to a wrong page. It aborts frames part of the way through, including one that would have switched the page. A shifter that kept its bit count, or lost the pending response at abort, would corrupt the next frame or drop the awaited read data. It writes single bytes and reads them back through odd addresses and other pages, which exposes a swapped byte lane or pages that alias each other. It checks the zero response after a write, back-to-back frames under one select, the exact length of the data-ready pulse, and the reset state taken in the middle of a run.

// File: rtl/pspi_pkg.sv
package pspi_pkg;

  localparam int FRAME_W = 16;
  localparam int BADDR_W = 7;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic               wr;
    logic [BADDR_W-1:0] baddr;
    logic [BYTE_W-1:0]  data;
  } frame_t;

endpackage

// File: rtl/pspi_shifter.sv
// Serial shifter: synchronizes the serial pins, captures frames on rising
// edges and shifts the pending response out on falling edges.
module pspi_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  input  logic [FRAME_W-1:0] resp_i,
  input  logic               resp_upd_i,
  output logic               miso,
  output logic               cs_act_o,
  output logic               fr_valid_o,
  output logic [FRAME_W-1:0] fr_word_o
);

  localparam int CNT_W = $clog2(FRAME_W);

  logic sclk_m, sclk_s, sclk_p;
  logic cs_m, cs_s, cs_p;
  logic mosi_m, mosi_s;

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] fw_q, fw_d;
  logic               miso_q, miso_d;
  logic               fv_q, fv_d;

  logic rise, fall, cs_act, cs_start, last_bit;

  assign rise     = sclk_s & ~sclk_p;
  assign fall     = ~sclk_s & sclk_p;
  assign cs_act   = ~cs_s;
  assign cs_start = ~cs_s & cs_p;
  assign last_bit = (cnt_q == CNT_W'(FRAME_W - 1));

  // input synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m <= 1'b1;
      sclk_s <= 1'b1;
      sclk_p <= 1'b1;
      cs_m   <= 1'b1;
      cs_s   <= 1'b1;
      cs_p   <= 1'b1;
      mosi_m <= 1'b0;
      mosi_s <= 1'b0;
    end else begin
      sclk_m <= sclk;
      sclk_s <= sclk_m;
      sclk_p <= sclk_s;
      cs_m   <= cs_n;
      cs_s   <= cs_m;
      cs_p   <= cs_s;
      mosi_m <= mosi;
      mosi_s <= mosi_m;
    end
  end

  // next-state logic
  always_comb begin
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    fw_d   = fw_q;
    miso_d = miso_q;
    fv_d   = 1'b0;
    if (!cs_act) begin
      cnt_d  = '0;
      miso_d = 1'b0;
    end else begin
      if (cs_start || resp_upd_i) begin
        tx_d = resp_i;
      end
      if (rise) begin
        rx_d = {rx_q[FRAME_W-2:0], mosi_s};
        if (last_bit) begin
          cnt_d = '0;
          fv_d  = 1'b1;
          fw_d  = {rx_q[FRAME_W-2:0], mosi_s};
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      if (fall) begin
        miso_d = tx_q[FRAME_W-1];
        tx_d   = {tx_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  logic rx_en, tx_en;
  assign rx_en = cs_act & rise;
  assign tx_en = cs_act & (cs_start | resp_upd_i | fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      fw_q   <= '0;
      miso_q <= 1'b0;
      fv_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      miso_q <= miso_d;
      fv_q   <= fv_d;
      if (rx_en) rx_q <= rx_d;
      if (tx_en) tx_q <= tx_d;
      if (fv_d)  fw_q <= fw_d;
    end
  end

  assign miso       = miso_q;
  assign cs_act_o   = cs_act;
  assign fr_valid_o = fv_q;
  assign fr_word_o  = fw_q;

endmodule

// File: rtl/pspi_decode.sv
// Command decode: page-select register, byte write requests, response word.
module pspi_decode
  import pspi_pkg::*;
#(
  parameter int NUM_PAGES = 13,
  parameter int REGS      = 64,
  parameter int DATA_W    = 16,
  localparam int PG_W     = $clog2(NUM_PAGES),
  localparam int IDX_W    = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_valid_i,
  input  logic [FRAME_W-1:0] fr_word_i,
  input  logic [DATA_W-1:0] rd_word_i,
  output logic              bank_wr_o,
  output logic              bank_hi_o,
  output logic [BYTE_W-1:0] bank_byte_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PG_W-1:0]   page_o,
  output logic [DATA_W-1:0] resp_o,
  output logic              resp_upd_o
);

  frame_t            fr;
  logic [IDX_W-1:0]  idx;
  logic              hi, is_sel, code_ok;
  logic [PG_W-1:0]   page_q, page_d;
  logic [DATA_W-1:0] resp_q, resp_d;
  logic              upd_q, upd_d;

  assign fr      = frame_t'(fr_word_i);
  assign idx     = fr.baddr[IDX_W:1];
  assign hi      = fr.baddr[0];
  assign is_sel  = (idx == '0);
  assign code_ok = !hi && (fr.data < BYTE_W'(NUM_PAGES));

  assign bank_wr_o   = fr_valid_i & fr.wr & ~is_sel;
  assign bank_hi_o   = hi;
  assign bank_byte_o = fr.data;
  assign idx_o       = idx;
  assign page_o      = page_q;

  always_comb begin
    page_d = page_q;
    resp_d = resp_q;
    upd_d  = 1'b0;
    if (fr_valid_i) begin
      upd_d = 1'b1;
      if (fr.wr) begin
        resp_d = '0;
        if (is_sel && code_ok) begin
          page_d = PG_W'(fr.data);
        end
      end else if (is_sel) begin
        resp_d = DATA_W'(page_q);
      end else begin
        resp_d = rd_word_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      resp_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= upd_d;
      if (fr_valid_i) begin
        page_q <= page_d;
        resp_q <= resp_d;
      end
    end
  end

  assign resp_o     = resp_q;
  assign resp_upd_o = upd_q;

endmodule

// File: rtl/pspi_bank.sv
// Register storage: one 16-bit word per page and index; index 0 is the
// page-select register and holds no storage here.
module pspi_bank
  import pspi_pkg::*;
#(
  parameter int NUM_PAGES = 13,
  parameter int REGS      = 64,
  parameter int DATA_W    = 16,
  localparam int PG_W     = $clog2(NUM_PAGES),
  localparam int IDX_W    = $clog2(REGS),
  localparam int WORDS    = NUM_PAGES * REGS,
  localparam int FLAT_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [PG_W-1:0]   wr_page_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wr_byte_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [DATA_W-1:0] ld_word_i,
  input  logic [PG_W-1:0]   rd_page_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o
);

  logic [DATA_W-1:0] rd_arr [WORDS];
  logic [FLAT_W-1:0] rd_flat;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    for (genvar r = 0; r < REGS; r++) begin : g_reg
      if (r == 0) begin : g_sel
        assign rd_arr[p*REGS + r] = '0;
      end else begin : g_word
        localparam bit IS_P0 = (p == 0);
        logic [DATA_W-1:0] word_q, word_d;
        logic              spi_hit, ld_hit, en;

        assign spi_hit = wr_en_i && (wr_page_i == PG_W'(p)) && (wr_idx_i == IDX_W'(r));
        assign ld_hit  = IS_P0 && ld_en_i && (ld_idx_i == IDX_W'(r));
        assign en      = spi_hit | ld_hit;

        always_comb begin
          word_d = word_q;
          if (spi_hit) begin
            if (wr_hi_i) word_d[DATA_W-1:BYTE_W] = wr_byte_i;
            else         word_d[BYTE_W-1:0]      = wr_byte_i;
          end
          if (ld_hit) begin
            word_d = ld_word_i;
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)  word_q <= '0;
          else if (en) word_q <= word_d;
        end

        assign rd_arr[p*REGS + r] = word_q;
      end
    end
  end

  assign rd_flat   = FLAT_W'(rd_page_i) * FLAT_W'(REGS) + FLAT_W'(rd_idx_i);
  assign rd_word_o = rd_arr[rd_flat];

endmodule

// File: rtl/paged_spi_regs.sv
// Top: reset synchronizer, serial shifter, decode, storage, data-ready pulse.
module paged_spi_regs
  import pspi_pkg::*;
#(
  parameter int NUM_PAGES   = 13,
  parameter int REGS        = 64,
  parameter int DATA_W      = 16,
  parameter int DRDY_CYCLES = 4,
  localparam int PG_W       = $clog2(NUM_PAGES),
  localparam int IDX_W      = $clog2(REGS),
  localparam int DCNT_W     = $clog2(DRDY_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              sensor_load,
  input  logic [IDX_W-1:0]  sensor_idx,
  input  logic [DATA_W-1:0] sensor_data,
  output logic              data_ready
);

  // reset: asserted asynchronously, released on the clock
  logic rst_m_n, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_s_n <= rst_m_n;
    end
  end

  logic               cs_act, fr_valid, resp_upd;
  logic [FRAME_W-1:0] fr_word;
  logic [DATA_W-1:0]  resp_q, rd_word;
  logic               bank_wr, bank_hi;
  logic [BYTE_W-1:0]  bank_byte;
  logic [IDX_W-1:0]   idx;
  logic [PG_W-1:0]    page_q;

  pspi_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .mosi       (mosi),
    .resp_i     (resp_q),
    .resp_upd_i (resp_upd),
    .miso       (miso),
    .cs_act_o   (cs_act),
    .fr_valid_o (fr_valid),
    .fr_word_o  (fr_word)
  );

  pspi_decode #(.NUM_PAGES(NUM_PAGES), .REGS(REGS), .DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .fr_valid_i  (fr_valid),
    .fr_word_i   (fr_word),
    .rd_word_i   (rd_word),
    .bank_wr_o   (bank_wr),
    .bank_hi_o   (bank_hi),
    .bank_byte_o (bank_byte),
    .idx_o       (idx),
    .page_o      (page_q),
    .resp_o      (resp_q),
    .resp_upd_o  (resp_upd)
  );

  pspi_bank #(.NUM_PAGES(NUM_PAGES), .REGS(REGS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .wr_en_i   (bank_wr),
    .wr_page_i (page_q),
    .wr_idx_i  (idx),
    .wr_hi_i   (bank_hi),
    .wr_byte_i (bank_byte),
    .ld_en_i   (sensor_load),
    .ld_idx_i  (sensor_idx),
    .ld_word_i (sensor_data),
    .rd_page_i (page_q),
    .rd_idx_i  (idx),
    .rd_word_o (rd_word)
  );

  // data-ready pulse stretcher
  logic [DCNT_W-1:0] dcnt_q, dcnt_d;
  logic              dcnt_en;

  always_comb begin
    dcnt_d = dcnt_q;
    if (sensor_load)        dcnt_d = DCNT_W'(DRDY_CYCLES);
    else if (dcnt_q != '0)  dcnt_d = dcnt_q - DCNT_W'(1);
  end

  assign dcnt_en = sensor_load | (dcnt_q != '0);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     dcnt_q <= '0;
    else if (dcnt_en) dcnt_q <= dcnt_d;
  end

  assign data_ready = (dcnt_q != '0);

endmodule

// File: rtl/pspi_checker.sv
module pspi_checker #(
  parameter int NUM_PAGES = 13,
  parameter int PG_W      = 4,
  parameter int DATA_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              miso,
  input logic              fr_valid,
  input logic [15:0]       fr_word,
  input logic [PG_W-1:0]   page_q,
  input logic [DATA_W-1:0] resp_q,
  input logic              sensor_load,
  input logic              data_ready
);

  // R1: a completed frame is a one-cycle event
  a_r1_single_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid |=> !fr_valid);

  // R3: a write frame queues a zero response
  a_r3_write_zero_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_word[15]) |=> (resp_q == '0));

  // R4: reading the page-select register returns the page code
  a_r4_page_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_word[15] && (fr_word[14:9] == '0)) |=> (resp_q == DATA_W'(page_q)));

  // R5: bad codes and upper-byte writes leave the page alone
  a_r5_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_word[15] && (fr_word[14:9] == '0) &&
     (fr_word[8] || (fr_word[7:0] >= 8'(NUM_PAGES)))) |=> $stable(page_q));

  // R9: data ready rises after a sensor load
  a_r9_drdy_start: assert property (@(posedge clk) disable iff (!rst_n)
    sensor_load |=> data_ready);

  // R10: miso stays low while deselected
  a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso);

endmodule

bind paged_spi_regs pspi_checker #(
  .NUM_PAGES (NUM_PAGES),
  .PG_W      (PG_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_s_n),
  .cs_act      (cs_act),
  .miso        (miso),
  .fr_valid    (fr_valid),
  .fr_word     (fr_word),
  .page_q      (page_q),
  .resp_q      (resp_q),
  .sensor_load (sensor_load),
  .data_ready  (data_ready)
);

// File: tb/tb_paged_spi_regs.sv
`timescale 1ns/1ps
module tb_paged_spi_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sclk, cs_n, mosi;
  logic        miso;
  logic        sensor_load;
  logic [5:0]  sensor_idx;
  logic [15:0] sensor_data;
  logic        data_ready;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  paged_spi_regs dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .sensor_load(sensor_load), .sensor_idx(sensor_idx), .sensor_data(sensor_data),
    .data_ready(data_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one mode-3 frame, nbits long; hold keeps cs_n low afterwards
  task automatic frame(input logic [15:0] tx, input int nbits, input bit hold, output logic [15:0] rx);
    rx = '0;
    if (cs_n) begin
      cs_n = 1'b0;
      wait_clk(8);
    end
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = tx[15-i];
      wait_clk(8);
      rx[15-i] = miso;
      sclk = 1'b1;
      wait_clk(8);
    end
    wait_clk(8);
    if (!hold) begin
      cs_n = 1'b1;
      wait_clk(10);
    end
  endtask

  task automatic wr_byte(input logic [6:0] a, input logic [7:0] d);
    logic [15:0] rx;
    frame({1'b1, a, d}, 16, 1'b0, rx);
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [15:0] v);
    logic [15:0] rx;
    frame({1'b0, a, 8'h00}, 16, 1'b0, rx);
    frame(16'h0000, 16, 1'b0, v);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(5);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(miso == 1'b0, "R8 miso after reset", 16'(miso), 16'h0);
    chk(data_ready == 1'b0, "R8 data_ready after reset", 16'(data_ready), 16'h0);
    rd_reg(7'h00, v);
    chk(v == 16'h0000, "R8 page after reset", v, 16'h0000);
    rd_reg(7'h10, v);
    chk(v == 16'h0000, "R8 register cleared", v, 16'h0000);
  endtask

  task automatic t_bytes();
    logic [15:0] v;
    wr_byte(7'h10, 8'hA5);
    wr_byte(7'h11, 8'h3C);
    rd_reg(7'h10, v);
    chk(v == 16'h3CA5, "R1 R2 byte lanes", v, 16'h3CA5);
    wr_byte(7'h10, 8'h5A);
    rd_reg(7'h11, v);
    chk(v == 16'h3C5A, "R2 R3 low byte only via odd read", v, 16'h3C5A);
  endtask

  task automatic t_pages();
    logic [15:0] v;
    wr_byte(7'h00, 8'h03);
    rd_reg(7'h00, v);
    chk(v == 16'h0003, "R4 page select read", v, 16'h0003);
    rd_reg(7'h01, v);
    chk(v == 16'h0003, "R4 page select odd read", v, 16'h0003);
    rd_reg(7'h10, v);
    chk(v == 16'h0000, "R6 fresh page", v, 16'h0000);
    wr_byte(7'h10, 8'h77);
    wr_byte(7'h00, 8'h00);
    rd_reg(7'h10, v);
    chk(v == 16'h3C5A, "R6 page 0 intact", v, 16'h3C5A);
    wr_byte(7'h00, 8'h03);
    rd_reg(7'h10, v);
    chk(v == 16'h0077, "R6 page 3 value", v, 16'h0077);
  endtask

  task automatic t_bad_code();
    logic [15:0] v;
    wr_byte(7'h00, 8'd13);
    rd_reg(7'h00, v);
    chk(v == 16'h0003, "R5 code 13 ignored", v, 16'h0003);
    wr_byte(7'h00, 8'hFF);
    rd_reg(7'h00, v);
    chk(v == 16'h0003, "R5 code FF ignored", v, 16'h0003);
    wr_byte(7'h01, 8'h05);
    rd_reg(7'h00, v);
    chk(v == 16'h0003, "R5 upper byte ignored", v, 16'h0003);
    wr_byte(7'h00, 8'd12);
    rd_reg(7'h00, v);
    chk(v == 16'h000C, "R4 last page code", v, 16'h000C);
    wr_byte(7'h00, 8'h00);
  endtask

  task automatic t_write_resp();
    logic [15:0] rx;
    frame({1'b0, 7'h10, 8'h00}, 16, 1'b0, rx);
    frame({1'b1, 7'h30, 8'h01}, 16, 1'b0, rx);
    chk(rx == 16'h3C5A, "R3 read data in next frame", rx, 16'h3C5A);
    frame(16'h0000, 16, 1'b0, rx);
    chk(rx == 16'h0000, "R3 zero after write", rx, 16'h0000);
  endtask

  task automatic t_abort();
    logic [15:0] rx, v;
    frame({1'b0, 7'h10, 8'h00}, 16, 1'b0, rx);
    frame({1'b1, 7'h00, 8'h05}, 9, 1'b0, rx);
    frame({1'b0, 7'h00, 8'h00}, 16, 1'b0, rx);
    chk(rx == 16'h3C5A, "R7 pending response kept", rx, 16'h3C5A);
    frame(16'h0000, 16, 1'b0, rx);
    chk(rx == 16'h0000, "R7 page unchanged by partial", rx, 16'h0000);
    frame({1'b1, 7'h20, 8'h99}, 15, 1'b0, rx);
    rd_reg(7'h20, v);
    chk(v == 16'h0000, "R7 partial write dropped", v, 16'h0000);
  endtask

  task automatic t_b2b();
    logic [15:0] rx;
    frame({1'b1, 7'h20, 8'h11}, 16, 1'b1, rx);
    frame({1'b0, 7'h20, 8'h00}, 16, 1'b1, rx);
    chk(rx == 16'h0000, "R11 second frame after write", rx, 16'h0000);
    frame({1'b0, 7'h00, 8'h00}, 16, 1'b0, rx);
    chk(rx == 16'h0011, "R11 third frame data", rx, 16'h0011);
    frame(16'h0000, 16, 1'b0, rx);
    chk(rx == 16'h0000, "R11 page after burst", rx, 16'h0000);
  endtask

  task automatic t_sensor();
    logic [15:0] v;
    int hi;
    bit first;
    sensor_idx  = 6'd5;
    sensor_data = 16'hBEEF;
    sensor_load = 1'b1;
    wait_clk(1);
    sensor_load = 1'b0;
    first = data_ready;
    hi = 0;
    for (int i = 0; i < 7; i++) begin
      if (data_ready) hi++;
      wait_clk(1);
    end
    chk(first == 1'b1, "R9 data_ready starts", 16'(first), 16'h1);
    chk(hi == 4, "R9 data_ready width", 16'(hi), 16'd4);
    rd_reg(7'h0A, v);
    chk(v == 16'hBEEF, "R9 sensor word even", v, 16'hBEEF);
    rd_reg(7'h0B, v);
    chk(v == 16'hBEEF, "R9 sensor word odd", v, 16'hBEEF);
    sensor_idx  = 6'd0;
    sensor_data = 16'h0007;
    sensor_load = 1'b1;
    wait_clk(1);
    sensor_load = 1'b0;
    wait_clk(6);
    rd_reg(7'h00, v);
    chk(v == 16'h0000, "R9 index 0 ignored", v, 16'h0000);
  endtask

  task automatic t_idle();
    logic [15:0] v;
    mosi = 1'b1;
    for (int i = 0; i < 20; i++) begin
      sclk = 1'b0;
      wait_clk(8);
      sclk = 1'b1;
      wait_clk(8);
    end
    chk(miso == 1'b0, "R10 miso low when deselected", 16'(miso), 16'h0);
    rd_reg(7'h00, v);
    chk(v == 16'h0000, "R10 clocks while deselected ignored", v, 16'h0000);
    rd_reg(7'h20, v);
    chk(v == 16'h0011, "R10 register intact", v, 16'h0011);
  endtask

  task automatic t_reset_mid();
    logic [15:0] v;
    wr_byte(7'h00, 8'h02);
    do_reset();
    chk(miso == 1'b0, "R8 miso after mid reset", 16'(miso), 16'h0);
    rd_reg(7'h00, v);
    chk(v == 16'h0000, "R8 page after mid reset", v, 16'h0000);
    rd_reg(7'h10, v);
    chk(v == 16'h0000, "R8 storage after mid reset", v, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0;
    sclk = 1'b1;
    cs_n = 1'b1;
    mosi = 1'b0;
    sensor_load = 1'b0;
    sensor_idx = '0;
    sensor_data = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(6);
    t_reset();
    t_bytes();
    t_pages();
    t_bad_code();
    t_write_resp();
    t_abort();
    t_b2b();
    t_sensor();
    t_idle();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule